// File: doc/BRIEF.md
# Bit-Serial Adder with Carry Flip-Flop

This block adds two unsigned operands of `W` bits, one bit position per clock cycle. The two operands sit in two shift registers that move right together, so the least significant bits meet first. A single carry flip-flop carries the result of each position into the next one. It behaves as a JK element: it is set when both operand bits are 1, cleared when both are 0, and otherwise keeps its value. Each new sum bit enters register A at its most significant end, so A holds the complete sum once the operation ends.

A small controller sequences the work through three states. In `SA_IDLE` the block accepts a parallel load of both operands or a start pulse. The transition `go` (start without load) clears the carry and enters `SA_SHIFT`. That state performs exactly `W` shifts, counted by a cycle counter. The transition `last` moves it to `SA_FINISH`, which raises `done_o` for a single cycle. The transition `back` then returns the block to `SA_IDLE`. While the sum is being formed, register B takes in a serial input at its top end. A new B operand can therefore be streamed in during one addition and used by the next one without a parallel load.

Top module: `bitser_adder`

## Requirements
- R1: In `SA_IDLE`, `load_i` = 1 copies `a_par_i` into register A (shown on `sum_o` the next cycle) and `b_par_i` into register B. When `load_i` and `start_i` are both 1, the load is taken and the start is ignored.
- R2: On every shift, the carry becomes 1 if both current operand bits (A bit 0, B bit 0) are 1, becomes 0 if both are 0, and otherwise keeps its value.
- R3: On every shift, register A moves one place toward bit 0, and the bit XOR of A bit 0, B bit 0 and the stored carry enters A bit `W`-1.
- R4: On every shift, register B moves one place toward bit 0 and `b_ser_i` enters B bit `W`-1. After an addition, B holds the `W` serial bits with the first one at bit 0, and a following addition started without a load uses that value.
- R5: An addition performs exactly `W` shifts. When `done_o` is 1, `sum_o` equals (A + B) mod 2^`W` of the operands present at the start.
- R6: `done_o` is 1 for exactly one cycle, in the cycle after the `W`-th shift, and is 0 at all other times.
- R7: `start_i` in `SA_IDLE` without `load_i` clears the carry before the first shift. `start_i` and `load_i` have no effect during `SA_SHIFT` and `SA_FINISH`.
- R8: `cout_o` shows the carry flip-flop. After completion it equals bit `W` of the sum, and it holds that value until the next accepted start.
- R9: Synchronous reset (`rst` = 1 at a rising edge) clears A, B, the carry and `done_o`, and returns the controller to `SA_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Parallel load of both operands (idle only) |
| a_par_i | input | W | Parallel value for register A |
| b_par_i | input | W | Parallel value for register B |
| start_i | input | 1 | Start pulse for an addition (idle only) |
| b_ser_i | input | 1 | Serial bit shifted into the top of register B |
| sum_o | output | W | Contents of register A (the sum after completion) |
| cout_o | output | 1 | Carry flip-flop (carry-out after completion) |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The bench builds the block with `W` = 8. This makes an eight-step carry chain such as 0xFF + 0x01 possible, along with the all-ones and all-zeros operands, while every operation stays short enough to check each intermediate register state. At that width, an addition chained from serially streamed operands can be checked against plain integer arithmetic. The same holds for inputs poked in the middle of an addition and for a reset that arrives in the middle of an operation.

// File: rtl/bitser_pkg.sv
package bitser_pkg;

    typedef enum logic [1:0] {
        SA_IDLE   = 2'd0,
        SA_SHIFT  = 2'd1,
        SA_FINISH = 2'd2
    } sa_state_e;

endpackage

// File: rtl/bitser_ctrl.sv
module bitser_ctrl
    import bitser_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic start_i,
    output logic idle_o,
    output logic shift_o,
    output logic clr_o,
    output logic ld_o,
    output logic done_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    sa_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic           at_last;

    assign at_last = (cnt_q == LAST);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SA_IDLE;
        else     state_q <= state_d;
    end

    // shift counter: runs only while shifting
    always_ff @(posedge clk) begin
        if (rst)                    cnt_q <= '0;
        else if (state_q == SA_SHIFT) cnt_q <= cnt_q + 1'b1;
        else                        cnt_q <= '0;
    end

    // transitions: go, last, back
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SA_IDLE:   if (start_i && !load_i) state_d = SA_SHIFT;
            SA_SHIFT:  if (at_last)            state_d = SA_FINISH;
            SA_FINISH:                         state_d = SA_IDLE;
            default:                           state_d = SA_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        idle_o  = 1'b0;
        shift_o = 1'b0;
        clr_o   = 1'b0;
        ld_o    = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            SA_IDLE: begin
                idle_o = 1'b1;
                ld_o   = load_i;
                clr_o  = start_i && !load_i;
            end
            SA_SHIFT:  shift_o = 1'b1;
            SA_FINISH: done_o  = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/bitser_shreg.sv
module bitser_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         shift,
    input  logic         ser_in,
    output logic [W-1:0] q
);
    generate
        if (W > 1) begin : g_wide
            always_ff @(posedge clk) begin
                if (rst)        q <= '0;
                else if (ld)    q <= ld_val;
                else if (shift) q <= {ser_in, q[W-1:1]};
            end
        end else begin : g_one
            always_ff @(posedge clk) begin
                if (rst)        q <= '0;
                else if (ld)    q <= ld_val;
                else if (shift) q <= ser_in;
            end
        end
    endgenerate

endmodule

// File: rtl/bitser_carry.sv
module bitser_carry (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic x,
    input  logic y,
    output logic q,
    output logic sum
);
    logic j_in, k_in;

    assign j_in = x & y;
    assign k_in = ~x & ~y;
    assign sum  = x ^ y ^ q;

    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (clr) q <= 1'b0;
        else if (en)  q <= (j_in & ~q) | (~k_in & q);
    end

endmodule

// File: rtl/bitser_adder.sv
module bitser_adder #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] a_par_i,
    input  logic [W-1:0] b_par_i,
    input  logic         start_i,
    input  logic         b_ser_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         done_o
);
    logic         idle_w, shift_en, clr_w, ld_w;
    logic [W-1:0] a_q, b_q;
    logic         sum_bit;

    bitser_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .start_i (start_i),
        .idle_o  (idle_w),
        .shift_o (shift_en),
        .clr_o   (clr_w),
        .ld_o    (ld_w),
        .done_o  (done_o)
    );

    bitser_shreg #(.W(W)) u_areg (
        .clk    (clk),
        .rst    (rst),
        .ld     (ld_w),
        .ld_val (a_par_i),
        .shift  (shift_en),
        .ser_in (sum_bit),
        .q      (a_q)
    );

    bitser_shreg #(.W(W)) u_breg (
        .clk    (clk),
        .rst    (rst),
        .ld     (ld_w),
        .ld_val (b_par_i),
        .shift  (shift_en),
        .ser_in (b_ser_i),
        .q      (b_q)
    );

    bitser_carry u_cy (
        .clk (clk),
        .rst (rst),
        .clr (clr_w),
        .en  (shift_en),
        .x   (a_q[0]),
        .y   (b_q[0]),
        .q   (cout_o),
        .sum (sum_bit)
    );

    assign sum_o = a_q;

endmodule

// File: rtl/bitser_adder_chk.sv
module bitser_adder_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         load_i,
    input logic         start_i,
    input logic [W-1:0] a_par_i,
    input logic         shift,
    input logic         idle,
    input logic         b_lsb,
    input logic [W-1:0] sum_o,
    input logic         cout_o,
    input logic         done_o
);
    // R1
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && load_i) |=> sum_o == $past(a_par_i));

    // R3
    sum_bit_chk: assert property (@(posedge clk) disable iff (rst)
        shift |=> sum_o[W-1] == ($past(sum_o[0]) ^ $past(b_lsb) ^ $past(cout_o)));

    // R2
    carry_jk_chk: assert property (@(posedge clk) disable iff (rst)
        shift |=> cout_o == (($past(sum_o[0]) & $past(b_lsb)) |
                             ($past(cout_o) & ($past(sum_o[0]) | $past(b_lsb)))));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R5
    done_after_shift_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(shift));

    // R7
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && start_i && !load_i) |=> !cout_o);

    // R8
    carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift && !(idle && start_i && !load_i)) |=> $stable(cout_o));

endmodule

bind bitser_adder bitser_adder_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .start_i (start_i),
    .a_par_i (a_par_i),
    .shift   (shift_en),
    .idle    (idle_w),
    .b_lsb   (b_q[0]),
    .sum_o   (sum_o),
    .cout_o  (cout_o),
    .done_o  (done_o)
);

// File: tb/bitser_adder_bench.sv
module bitser_adder_bench;
    localparam int W      = 8;
    localparam int PERIOD = 10;
    localparam int MASK   = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_i = 1'b0;
    logic [W-1:0] a_par_i = '0;
    logic [W-1:0] b_par_i = '0;
    logic         start_i = 1'b0;
    logic         b_ser_i = 1'b0;
    logic [W-1:0] sum_o;
    logic         cout_o;
    logic         done_o;

    int n_cmp = 0;
    int n_bad = 0;

    bitser_adder #(.W(W)) u_bitser_adder (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load_i),
        .a_par_i (a_par_i),
        .b_par_i (b_par_i),
        .start_i (start_i),
        .b_ser_i (b_ser_i),
        .sum_o   (sum_o),
        .cout_o  (cout_o),
        .done_o  (done_o)
    );

    always #(PERIOD/2) clk = ~clk;

    // reference model: whole-word arithmetic
    int    phase = 0;   // 0 idle, 1 adding, 2 finished
    int    k = 0;
    int    mA = 0, mB = 0, mC = 0;
    int    a0 = 0, b0 = 0, sb = 0;
    bit    poke = 0, chain = 0;
    string idle_tag = "R9";

    always @(posedge clk) begin
        if (rst) begin
            phase = 0; mA = 0; mB = 0; mC = 0; k = 0;
        end else begin
            case (phase)
                0: begin
                    if (load_i) begin
                        mA = int'(a_par_i); mB = int'(b_par_i);
                    end else if (start_i) begin
                        mC = 0; a0 = mA; b0 = mB; sb = 0; k = 0; phase = 1;
                    end
                end
                1: begin
                    int lm;
                    sb = sb | (int'(b_ser_i) << k);
                    k  = k + 1;
                    lm = (1 << k) - 1;
                    mA = ((a0 >> k) | (((a0 + b0) & lm) << (W - k))) & MASK;
                    mB = ((b0 >> k) | (sb << (W - k))) & MASK;
                    mC = (((a0 & lm) + (b0 & lm)) >> k) & 1;
                    if (k == W) phase = 2;
                end
                default: phase = 0;
            endcase
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            string st, ct;
            st = (phase == 2) ? (chain ? "R4" : "R5")
               : (phase == 1) ? (poke ? "R7" : "R3") : idle_tag;
            ct = (phase == 1) ? ((k == 1) ? "R7" : "R2")
               : (phase == 2) ? "R8" : idle_tag;
            check(st, int'(sum_o), mA);
            check(ct, int'(cout_o), mC);
            check("R6", int'(done_o), (phase == 2) ? 1 : 0);
        end
    end

    task automatic do_load(input int a, input int b);
        @(negedge clk);
        load_i = 1'b1; a_par_i = W'(a); b_par_i = W'(b);
        @(negedge clk);
        load_i = 1'b0;
        idle_tag = "R1";
    endtask

    task automatic do_add(input int ser, input bit pk, input bit ch);
        chain = ch;
        @(negedge clk);
        start_i = 1'b1;
        for (int j = 0; j < W; j++) begin
            @(negedge clk);
            start_i = 1'b0;
            b_ser_i = ser[j];
            if (pk && j == 2) begin
                poke = 1'b1; load_i = 1'b1; start_i = 1'b1;
                a_par_i = 8'hA5; b_par_i = 8'h3C;
            end else begin
                load_i = 1'b0;
            end
        end
        @(negedge clk);
        b_ser_i = 1'b0; load_i = 1'b0; start_i = 1'b0;
        @(negedge clk);
        poke = 1'b0; chain = 1'b0;
        idle_tag = "R8";
    endtask

    initial begin
        #(PERIOD * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle_tag = "R9";
        @(negedge clk);
        // R9 reset state
        check("R9", int'(sum_o), 0);
        check("R9", int'(done_o), 0);

        do_load(8'h5A, 8'h33);  do_add(8'hC3, 0, 0);
        do_load(8'hFF, 8'h01);  do_add(8'h00, 0, 0);  // full carry chain
        do_load(8'h00, 8'h00);  do_add(8'hFF, 0, 0);
        // R4 chained operand from serial stream
        do_add(8'h81, 0, 1);
        do_load(8'hFF, 8'hFF);  do_add(8'h6D, 0, 0);
        // R8 idle hold
        repeat (4) @(negedge clk);
        // R7 pokes during adding
        do_load(8'h12, 8'hF0);  do_add(8'h0F, 1, 0);

        // R1 load wins over start
        @(negedge clk);
        load_i = 1'b1; start_i = 1'b1; a_par_i = 8'h77; b_par_i = 8'h99;
        @(negedge clk);
        load_i = 1'b0; start_i = 1'b0; idle_tag = "R1";
        repeat (2) @(negedge clk);
        do_add(8'h55, 0, 0);

        // R9 reset mid-operation
        do_load(8'h3E, 8'h4B);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; idle_tag = "R9";
        repeat (2) @(negedge clk);
        do_load(8'h80, 8'h80);  do_add(8'hAA, 0, 0);

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule